// File: doc/BRIEF.md
# Dual-Channel Compare Timer

An 8-bit timer/counter with two compare channels that each drive an output pin. The counter moves one step on every clock cycle where the tick enable input is high. The tick normally comes from a prescaler outside the block. A third compare register can set the turning point of the count.

Three counting behaviours are available:

- **Free-running:** the counter counts up to its full range.
- **Clear-on-match:** the counter counts up to the third compare register and then restarts from zero.
- **Symmetric up/down PWM:** the counter counts up to the third compare register, then back down to zero.

On a compare match, each channel raises a one-cycle flag pulse and may change its pin. In the counting modes the pin can toggle, clear or set. In PWM mode the pin's polarity follows the count direction.

Software loads the counter, the compare registers and the configuration through plain write strobes with a shared data bus. A force strobe per channel applies the channel's pin action at once.

All ports are plain control and status pins. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_cmp_timer`

## Requirements
- R1: The turning value is compare register C whenever clear-on-match or either PWM enable is set. Otherwise it is 255.
- R2: In free-running and clear-on-match operation, each tick adds one to the count. When the count is at or above the turning value, the tick moves it to 0 instead. `ovf_o` pulses high for the one cycle after a wrapping tick. A cycle without a tick leaves the count unchanged.
- R3: When a PWM enable is set and clear-on-match is clear, the counter operates in PWM mode:
  - ticks count up until the turning value is reached, then count down to 0, then count up again;
  - `ovf_o` pulses only in the cycle after a tick that brings the count down to 0;
  - reaching the turning value raises no overflow.
- R4: In every mode, a tick whose new count equals compare register A pulses `match_a_o` for one cycle. Register B does the same for `match_b_o`. Both pulses appear in the same cycle as the new count.
- R5: Outside PWM mode, a channel whose own PWM enable is clear acts on its pin at a match. Its 2-bit output mode selects the action: 0 holds the pin, 1 toggles it, 2 drives it to 0 and 3 drives it to 1.
- R6: In PWM mode, a match acts on the pin according to the direction the counter has after the step:
  - mode 2 drives the pin to 0 when counting up and to 1 when counting down;
  - mode 3 does the reverse;
  - mode 1 toggles the pin.
- R7: A force strobe applies the R5 action of its channel in the next cycle and raises no match pulse. It has no effect while that channel's PWM enable is set or its output mode is 0.
- R8: A channel's pin-drive enable output is high exactly when its stored output mode is nonzero.
- R9: A counter write loads the value and sets the direction to up. It takes priority over a tick in the same cycle. That cycle produces no match or overflow pulse and no pin change.
- R10: After reset the count is 0, both pins are 0, and all pulses and drive enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for this cycle |
| wr_data_i | input | 8 | Data for counter and compare writes |
| cnt_we_i | input | 1 | Load counter from `wr_data_i` |
| cmp_a_we_i | input | 1 | Write compare register A |
| cmp_b_we_i | input | 1 | Write compare register B |
| cmp_c_we_i | input | 1 | Write compare register C (turning value) |
| cfg_we_i | input | 1 | Store the configuration fields below |
| cfg_ctc_i | input | 1 | Clear-on-match enable |
| cfg_pwm_a_i | input | 1 | PWM enable, channel A |
| cfg_pwm_b_i | input | 1 | PWM enable, channel B |
| cfg_mode_a_i | input | 2 | Output mode, channel A |
| cfg_mode_b_i | input | 2 | Output mode, channel B |
| force_a_i | input | 1 | Force strobe, channel A |
| force_b_i | input | 1 | Force strobe, channel B |
| count_o | output | 8 | Current count |
| pin_a_o | output | 1 | Channel A pin level |
| pin_b_o | output | 1 | Channel B pin level |
| drive_a_o | output | 1 | Channel A pin-drive enable |
| drive_b_o | output | 1 | Channel B pin-drive enable |
| ovf_o | output | 1 | Overflow pulse |
| match_a_o | output | 1 | Compare A match pulse |
| match_b_o | output | 1 | Compare B match pulse |

## Verification
The assertions expect the inputs to be at defined levels from the first cycle after reset. They also check the match-equality property only when the compare register was not rewritten on the same edge. They assume that a counter write and a tick in the same cycle resolve in favour of the write.

The stimulus always drives inputs at the falling edge. It returns every strobe to 0 before the next cycle. It never writes a compare register in a cycle that also ticks, so each match can be traced to a stable register value.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } pin_act_e;

  localparam int unsigned NUM_CH = 2;

  // Pin action for counting (non-PWM) operation, selected by output mode.
  function automatic pin_act_e plain_action(input logic [1:0] mode);
    pin_act_e a;
    case (mode)
      2'd1:    a = PIN_TOGGLE;
      2'd2:    a = PIN_LOW;
      2'd3:    a = PIN_HIGH;
      default: a = PIN_KEEP;
    endcase
    return a;
  endfunction

  // Pin action for up/down PWM operation, depending on direction after the step.
  function automatic pin_act_e pwm_action(input logic [1:0] mode, input logic going_up);
    pin_act_e a;
    case (mode)
      2'd1:    a = PIN_TOGGLE;
      2'd2:    a = going_up ? PIN_LOW : PIN_HIGH;
      2'd3:    a = going_up ? PIN_HIGH : PIN_LOW;
      default: a = PIN_KEEP;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] top_i,
  input  logic         updown_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         nxt_up_o,
  output logic         fire_o,
  output logic         ovf_o
);

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic [W:0]   inc;
  logic         wrap;
  logic         past_valid;

  assign inc    = {1'b0, cnt_q} + 1'b1;
  assign fire_o = tick_i & ~load_i;

  always_comb begin
    nxt_o    = cnt_q;
    nxt_up_o = up_q;
    wrap     = 1'b0;
    if (updown_i) begin
      if (up_q) begin
        if (inc >= {1'b0, top_i}) begin
          nxt_o    = top_i;
          nxt_up_o = 1'b0;
        end else begin
          nxt_o = inc[W-1:0];
        end
      end else begin
        if (cnt_q <= W'(1)) begin
          nxt_o    = '0;
          nxt_up_o = 1'b1;
          wrap     = 1'b1;
        end else begin
          nxt_o = cnt_q - 1'b1;
        end
      end
    end else begin
      nxt_up_o = 1'b1;
      if (cnt_q >= top_i) begin
        nxt_o = '0;
        wrap  = 1'b1;
      end else begin
        nxt_o = inc[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      up_q       <= 1'b1;
      ovf_o      <= 1'b0;
      past_valid <= 1'b0;
    end else begin
      past_valid <= 1'b1;
      ovf_o      <= fire_o & wrap;
      if (load_i) begin
        cnt_q <= load_val_i;
        up_q  <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= nxt_o;
        up_q  <= nxt_up_o;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R2 / R3: an overflow pulse always coincides with a count of zero
  p_ovf_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (cnt_o == '0));

  // R9: a load shows up verbatim on the next cycle
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(load_i) |-> (cnt_o == $past(load_val_i)));

  // R2: without tick or load, the count holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && !$past(tick_i) && !$past(load_i) |-> $stable(cnt_o));

endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire_i,
  input  logic [W-1:0] nxt_i,
  input  logic         nxt_up_i,
  input  logic [W-1:0] cmp_i,
  input  logic [1:0]   mode_i,
  input  logic         updown_i,
  input  logic         own_pwm_i,
  input  logic         force_i,
  output logic         flag_o,
  output logic         pin_o,
  output logic         drive_o
);
  import dct_pkg::*;

  logic     hit;
  logic     force_ok;
  pin_act_e act;
  logic     pin_q;
  logic     past_valid;

  assign hit      = fire_i && (nxt_i == cmp_i);
  assign force_ok = force_i && !own_pwm_i && (mode_i != 2'd0);

  always_comb begin
    act = PIN_KEEP;
    if (hit) begin
      if (updown_i)        act = pwm_action(mode_i, nxt_up_i);
      else if (!own_pwm_i) act = plain_action(mode_i);
    end
    if (force_ok) act = plain_action(mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q      <= 1'b0;
      flag_o     <= 1'b0;
      past_valid <= 1'b0;
    end else begin
      past_valid <= 1'b1;
      flag_o     <= hit;
      case (act)
        PIN_TOGGLE: pin_q <= ~pin_q;
        PIN_LOW:    pin_q <= 1'b0;
        PIN_HIGH:   pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o   = pin_q;
  assign drive_o = (mode_i != 2'd0);

  // R5: pin moves only after a match or force
  p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && !$past(hit) && !$past(force_i) |-> $stable(pin_o));

  // R4 / R7: a match pulse needs a counting step the cycle before
  p_flag_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |-> (past_valid && $past(fire_i)));

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         cnt_we_i,
  input  logic         cmp_a_we_i,
  input  logic         cmp_b_we_i,
  input  logic         cmp_c_we_i,
  input  logic         cfg_we_i,
  input  logic         cfg_ctc_i,
  input  logic         cfg_pwm_a_i,
  input  logic         cfg_pwm_b_i,
  input  logic [1:0]   cfg_mode_a_i,
  input  logic [1:0]   cfg_mode_b_i,
  input  logic         force_a_i,
  input  logic         force_b_i,
  output logic [W-1:0] count_o,
  output logic         pin_a_o,
  output logic         pin_b_o,
  output logic         drive_a_o,
  output logic         drive_b_o,
  output logic         ovf_o,
  output logic         match_a_o,
  output logic         match_b_o
);
  import dct_pkg::*;

  localparam int unsigned NCMP = NUM_CH + 1;

  logic [W-1:0] cmp_q [NCMP];
  logic [NCMP-1:0] cmp_we;
  logic         ctc_q;
  logic [NUM_CH-1:0] pwm_q;
  logic [1:0]   mode_q [NUM_CH];
  logic [1:0]   mode_in [NUM_CH];
  logic [NUM_CH-1:0] pwm_in;
  logic [NUM_CH-1:0] force_v, flag_v, pin_v, drive_v;

  logic [W-1:0] top;
  logic         updown;
  logic [W-1:0] nxt;
  logic         nxt_up;
  logic         fire;
  logic         past_valid;

  assign cmp_we     = {cmp_c_we_i, cmp_b_we_i, cmp_a_we_i};
  assign force_v    = {force_b_i, force_a_i};
  assign pwm_in     = {cfg_pwm_b_i, cfg_pwm_a_i};
  assign mode_in[0] = cfg_mode_a_i;
  assign mode_in[1] = cfg_mode_b_i;

  for (genvar r = 0; r < NCMP; r++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[r] <= '0;
      else if (cmp_we[r]) cmp_q[r] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctc_q      <= 1'b0;
      pwm_q      <= '0;
      past_valid <= 1'b0;
    end else begin
      past_valid <= 1'b1;
      if (cfg_we_i) begin
        ctc_q <= cfg_ctc_i;
        pwm_q <= pwm_in;
      end
    end
  end

  assign top    = (ctc_q || (|pwm_q)) ? cmp_q[NCMP-1] : '1;
  assign updown = (|pwm_q) && !ctc_q;

  dct_counter #(.W(W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (cnt_we_i),
    .load_val_i (wr_data_i),
    .top_i      (top),
    .updown_i   (updown),
    .cnt_o      (count_o),
    .nxt_o      (nxt),
    .nxt_up_o   (nxt_up),
    .fire_o     (fire),
    .ovf_o      (ovf_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q[c] <= 2'd0;
      else if (cfg_we_i) mode_q[c] <= mode_in[c];
    end

    dct_channel #(.W(W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .nxt_i     (nxt),
      .nxt_up_i  (nxt_up),
      .cmp_i     (cmp_q[c]),
      .mode_i    (mode_q[c]),
      .updown_i  (updown),
      .own_pwm_i (pwm_q[c]),
      .force_i   (force_v[c]),
      .flag_o    (flag_v[c]),
      .pin_o     (pin_v[c]),
      .drive_o   (drive_v[c])
    );

    // R4: a match pulse shows the count equal to its (unchanged) compare register
    p_match_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && flag_v[c] && !$past(cmp_we[c]) |-> (count_o == cmp_q[c]));
  end

  assign match_a_o = flag_v[0];
  assign match_b_o = flag_v[1];
  assign pin_a_o   = pin_v[0];
  assign pin_b_o   = pin_v[1];
  assign drive_a_o = drive_v[0];
  assign drive_b_o = drive_v[1];

endmodule

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;

  localparam int S_CNT = 0, S_PA = 1, S_PB = 2, S_OA = 3, S_OB = 4,
                 S_OVF = 5, S_MA = 6, S_MB = 7;

  typedef struct {
    int    at;
    int    sel;
    int    val;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, cnt_we = 0, ca_we = 0, cb_we = 0, cc_we = 0, cfg_we = 0;
  logic [7:0] wdata = '0;
  logic       c_ctc = 0, c_pa = 0, c_pb = 0, f_a = 0, f_b = 0;
  logic [1:0] c_ma = '0, c_mb = '0;
  logic [7:0] count;
  logic       pin_a, pin_b, drv_a, drv_b, ovf, m_a, m_b;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #2.5ns clk = ~clk;

  dual_cmp_timer u_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_data_i(wdata),
    .cnt_we_i(cnt_we), .cmp_a_we_i(ca_we), .cmp_b_we_i(cb_we), .cmp_c_we_i(cc_we),
    .cfg_we_i(cfg_we), .cfg_ctc_i(c_ctc), .cfg_pwm_a_i(c_pa), .cfg_pwm_b_i(c_pb),
    .cfg_mode_a_i(c_ma), .cfg_mode_b_i(c_mb), .force_a_i(f_a), .force_b_i(f_b),
    .count_o(count), .pin_a_o(pin_a), .pin_b_o(pin_b), .drive_a_o(drv_a),
    .drive_b_o(drv_b), .ovf_o(ovf), .match_a_o(m_a), .match_b_o(m_b)
  );

  function automatic int observe(int sel);
    case (sel)
      S_CNT:   return int'(count);
      S_PA:    return int'(pin_a);
      S_PB:    return int'(pin_b);
      S_OA:    return int'(drv_a);
      S_OB:    return int'(drv_b);
      S_OVF:   return int'(ovf);
      S_MA:    return int'(m_a);
      default: return int'(m_b);
    endcase
  endfunction

  // monitor: pops expectations due in this cycle and compares
  initial begin
    forever begin
      @(posedge clk);
      #1ns;
      cyc++;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        exp_t e;
        int   got;
        e   = sb.pop_front();
        got = observe(e.sel);
        n_chk++;
        if (got != e.val) begin
          n_bad++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%0d expected=%0d",
                   e.req, e.sel, cyc, got, e.val);
        end
      end
    end
  end

  // expectation for the result of the edge following the current drive
  task automatic ex(int sel, int val, string req);
    exp_t e;
    e.at = cyc + 1; e.sel = sel; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic begin_cyc();
    @(negedge clk);
    tick = 0; cnt_we = 0; ca_we = 0; cb_we = 0; cc_we = 0; cfg_we = 0;
    f_a = 0; f_b = 0;
  endtask

  task automatic tk();
    begin_cyc(); tick = 1;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    begin_cyc(); cnt_we = 1; wdata = v;
  endtask

  task automatic wr_cmp(int which, logic [7:0] v);
    begin_cyc(); wdata = v;
    if (which == 0) ca_we = 1; else if (which == 1) cb_we = 1; else cc_we = 1;
  endtask

  task automatic cfg(bit ctc, bit pa, bit pb, logic [1:0] ma, logic [1:0] mb);
    begin_cyc(); cfg_we = 1; c_ctc = ctc; c_pa = pa; c_pb = pb; c_ma = ma; c_mb = mb;
  endtask

  task automatic frc(bit a, bit b);
    begin_cyc(); f_a = a; f_b = b;
  endtask

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    begin_cyc();
    ex(S_CNT, 0, "R10"); ex(S_PA, 0, "R10"); ex(S_PB, 0, "R10");
    ex(S_OVF, 0, "R10"); ex(S_MA, 0, "R10"); ex(S_OA, 0, "R10"); ex(S_OB, 0, "R10");

    // free-running: C ignored, full range wrap
    wr_cmp(2, 8'd5);
    wr_cnt(8'hFD);
    tk(); ex(S_CNT, 8'hFE, "R2"); ex(S_OVF, 0, "R2");
    tk(); ex(S_CNT, 8'hFF, "R1");
    tk(); ex(S_CNT, 0, "R2"); ex(S_OVF, 1, "R2"); ex(S_MA, 1, "R4"); ex(S_MB, 1, "R4");
    begin_cyc(); ex(S_CNT, 0, "R2"); ex(S_OVF, 0, "R2");

    // clear-on-match with toggle (A) and set (B)
    cfg(1, 0, 0, 2'd1, 2'd3); ex(S_OA, 1, "R8"); ex(S_OB, 1, "R8");
    wr_cmp(2, 8'd3);
    wr_cmp(0, 8'd2);
    wr_cnt(8'd0);
    tk(); ex(S_CNT, 1, "R2"); ex(S_MA, 0, "R4");
    tk(); ex(S_CNT, 2, "R2"); ex(S_MA, 1, "R4"); ex(S_PA, 1, "R5");
    tk(); ex(S_CNT, 3, "R1"); ex(S_OVF, 0, "R2");
    tk(); ex(S_CNT, 0, "R2"); ex(S_OVF, 1, "R2"); ex(S_MB, 1, "R4"); ex(S_PB, 1, "R5");
    tk(); ex(S_CNT, 1, "R2");
    tk(); ex(S_CNT, 2, "R2"); ex(S_PA, 0, "R5");

    // force with set mode, then clear mode at a match
    cfg(1, 0, 0, 2'd3, 2'd3);
    frc(1, 0); ex(S_PA, 1, "R7"); ex(S_MA, 0, "R7");
    cfg(1, 0, 0, 2'd2, 2'd3);
    tk(); ex(S_CNT, 3, "R2"); ex(S_PA, 1, "R5");
    tk(); ex(S_CNT, 0, "R2");
    tk(); ex(S_CNT, 1, "R2");
    tk(); ex(S_CNT, 2, "R2"); ex(S_PA, 0, "R5"); ex(S_MA, 1, "R4");

    // force ignored: mode 0, then PWM enabled on the channel
    cfg(1, 0, 0, 2'd0, 2'd3); ex(S_OA, 0, "R8");
    frc(1, 0); ex(S_PA, 0, "R7");
    cfg(1, 1, 0, 2'd3, 2'd3);
    frc(1, 0); ex(S_PA, 0, "R7");

    // load beats tick, no match pulse, no pin change
    cfg(1, 0, 0, 2'd1, 2'd3);
    begin_cyc(); tick = 1; cnt_we = 1; wdata = 8'd2;
    ex(S_CNT, 2, "R9"); ex(S_MA, 0, "R9"); ex(S_PA, 0, "R9"); ex(S_OVF, 0, "R9");
    tk(); ex(S_CNT, 3, "R9");

    // preset pins: A high, B low
    cfg(1, 0, 0, 2'd3, 2'd2);
    frc(1, 1); ex(S_PA, 1, "R7"); ex(S_PB, 0, "R7"); ex(S_MB, 0, "R7");

    // up/down PWM: top 4, A=2 mode 2, B=3 mode 3
    cfg(0, 1, 0, 2'd2, 2'd3);
    wr_cmp(2, 8'd4);
    wr_cmp(0, 8'd2);
    wr_cmp(1, 8'd3);
    wr_cnt(8'd0);
    tk(); ex(S_CNT, 1, "R3"); ex(S_PA, 1, "R6");
    tk(); ex(S_CNT, 2, "R3"); ex(S_MA, 1, "R4"); ex(S_PA, 0, "R6");
    tk(); ex(S_CNT, 3, "R3"); ex(S_MB, 1, "R4"); ex(S_PB, 1, "R6");
    tk(); ex(S_CNT, 4, "R3"); ex(S_OVF, 0, "R3");
    tk(); ex(S_CNT, 3, "R3"); ex(S_PB, 0, "R6");
    tk(); ex(S_CNT, 2, "R3"); ex(S_PA, 1, "R6");
    tk(); ex(S_CNT, 1, "R3"); ex(S_OVF, 0, "R3");
    tk(); ex(S_CNT, 0, "R3"); ex(S_OVF, 1, "R3");
    tk(); ex(S_CNT, 1, "R3"); ex(S_OVF, 0, "R3");
    tk(); ex(S_CNT, 2, "R3"); ex(S_PA, 0, "R6");
    tk(); ex(S_CNT, 3, "R3");
    tk(); ex(S_CNT, 4, "R3");

    // load while counting down resets direction to up
    wr_cnt(8'd3); ex(S_CNT, 3, "R9");
    tk(); ex(S_CNT, 4, "R9");

    repeat (4) begin_cyc();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule